// File: doc/BRIEF.md
# Gated-Enable Bit-Slice ALU

This block is a purely combinational arithmetic/logic unit made of identical one-bit slices, eight by default. A two-bit function select is decoded into four one-hot enable lines, one for each operation. Each slice computes a full-adder sum, the AND, the OR and the inverse of its B bit in parallel. It masks every one of those outputs with the matching enable and merges the masked terms with a wide OR. The slices are chained so that the carry leaving one slice enters the next.

The unit has no clock, no storage and no handshake: the result settles from the operands and the select alone. A stream wrapper, if one is needed, belongs around it and not inside it. The select encoding is fixed: 2'b00 adds, 2'b01 ANDs, 2'b10 ORs and 2'b11 passes the complement of B.

Top module: `gated_slice_alu`

## Requirements
- R1: Each value of `func_sel` raises exactly one of four internal enables: 2'b00 selects ADD, 2'b01 AND, 2'b10 OR and 2'b11 NOT B.
- R2: With `func_sel`=2'b00, `{carry_out, result}` equals `a_in + b_in + carry_in` as an unsigned 9-bit sum.
- R3: With `func_sel`=2'b01, `result` equals `a_in & b_in`.
- R4: With `func_sel`=2'b10, `result` equals `a_in | b_in`.
- R5: With `func_sel`=2'b11, `result` equals `~b_in`.
- R6: For every select other than 2'b00, `carry_out` is 0, because each slice masks its carry with the ADD enable.
- R7: `carry_in` has no effect on `result` or `carry_out` for the three logical operations.
- R8: A carry ripples through every slice: all-ones plus zero with `carry_in`=1 gives result 0 and `carry_out` 1, and so does 8'h01 plus 8'hFF.
- R9: Within any slice, at most one of the four masked terms is 1 at a time.
- R10: With `func_sel`=2'b11, the value of `a_in` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Operand A, shared by all operations |
| b_in | input | 8 | Operand B, shared by all operations |
| func_sel | input | 2 | Operation select (00 ADD, 01 AND, 10 OR, 11 NOT B) |
| carry_in | input | 1 | Carry into the least significant slice |
| result | output | 8 | Merged slice results |
| carry_out | output | 1 | Carry out of the most significant slice, 0 unless adding |

## Verification
Whenever the inputs change, immediate assertions check several properties. The decoder must raise exactly one enable. No slice may drive more than one masked term. The carry out of a slice must be 0 outside ADD. At the top, the NOT B and logical results must agree with the operands. Full carry propagation across the chain, the independence from `carry_in` for logical operations and the arithmetic value of the sum cannot be seen inside one slice. Only the bench's scenarios show these: random operands under every select with both carry-in values, the ripple extremes, and pairs of stimuli that differ in a single ignored input.

// File: rtl/gated_alu_pkg.sv
package gated_alu_pkg;
  localparam int unsigned NUM_OPS = 4;
  localparam int unsigned SEL_W   = $clog2(NUM_OPS);

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 2'b00,
    OP_AND  = 2'b01,
    OP_OR   = 2'b10,
    OP_NOTB = 2'b11
  } alu_op_e;

  typedef logic [NUM_OPS-1:0] op_en_t;
endpackage

// File: rtl/gated_op_decoder.sv
module gated_op_decoder
  import gated_alu_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output op_en_t           en
);
  for (genvar i = 0; i < NUM_OPS; i++) begin : g_dec
    assign en[i] = (sel == i[SEL_W-1:0]);
  end

  always_comb begin
    // R1
    one_enable_chk: assert ($countones(en) == 1)
      else $error("decoder raised %0d enables", $countones(en));
  end
endmodule

// File: rtl/gated_bit_slice.sv
module gated_bit_slice
  import gated_alu_pkg::*;
(
  input  logic   a,
  input  logic   b,
  input  logic   cin,
  input  op_en_t en,
  output logic   r,
  output logic   cout
);
  logic [NUM_OPS-1:0] raw;
  logic [NUM_OPS-1:0] masked;
  logic               raw_carry;

  always_comb begin
    raw[OP_ADD]  = a ^ b ^ cin;
    raw[OP_AND]  = a & b;
    raw[OP_OR]   = a | b;
    raw[OP_NOTB] = ~b;
    raw_carry    = (a & b) | (cin & (a ^ b));
  end

  for (genvar k = 0; k < NUM_OPS; k++) begin : g_mask
    assign masked[k] = raw[k] & en[k];
  end

  assign r    = |masked;
  assign cout = raw_carry & en[OP_ADD];

  always_comb begin
    // R9
    single_term_chk: assert ($countones(masked) <= 1)
      else $error("slice drove %0d masked terms", $countones(masked));
    // R6
    slice_carry_gated_chk: assert (en[OP_ADD] || !cout)
      else $error("slice carry set outside ADD");
  end
endmodule

// File: rtl/gated_slice_alu.sv
module gated_slice_alu
  import gated_alu_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic [SEL_W-1:0] func_sel,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  op_en_t         en;
  logic [WIDTH:0] chain;

  gated_op_decoder u_dec (
    .sel (func_sel),
    .en  (en)
  );

  assign chain[0] = carry_in;

  for (genvar s = 0; s < WIDTH; s++) begin : g_slice
    gated_bit_slice u_slice (
      .a    (a_in[s]),
      .b    (b_in[s]),
      .cin  (chain[s]),
      .en   (en),
      .r    (result[s]),
      .cout (chain[s+1])
    );
  end

  assign carry_out = chain[WIDTH];

  always_comb begin
    // R5
    notb_result_chk: assert (func_sel != OP_NOTB || result == ~b_in)
      else $error("NOT B result mismatch");
    // R3
    and_result_chk: assert (func_sel != OP_AND || result == (a_in & b_in))
      else $error("AND result mismatch");
    // R4
    or_result_chk: assert (func_sel != OP_OR || result == (a_in | b_in))
      else $error("OR result mismatch");
    // R6
    top_carry_gated_chk: assert (func_sel == OP_ADD || !carry_out)
      else $error("carry_out set outside ADD");
  end
endmodule

// File: tb/gated_slice_alu_bench.sv
module gated_slice_alu_bench;
  localparam int  W        = 8;
  localparam time CLK_HALF = 5ns;
  localparam int  WATCHDOG = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [1:0]   func_sel = 2'b00;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [W:0] exp_q[$];
  string      tag_q[$];

  always #CLK_HALF clk = ~clk;

  gated_slice_alu #(.WIDTH(W)) u_gated_slice_alu (
    .a_in(a_in), .b_in(b_in), .func_sel(func_sel), .carry_in(carry_in),
    .result(result), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                       logic [1:0] f, logic c);
    case (f)
      2'b00:   model = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c};
      2'b01:   model = {1'b0, a & b};
      2'b10:   model = {1'b0, a | b};
      default: model = {1'b0, ~b};
    endcase
  endfunction

  task automatic drive(logic [W-1:0] a, logic [W-1:0] b, logic [1:0] f,
                       logic c, string tag);
    @(posedge clk);
    a_in = a; b_in = b; func_sel = f; carry_in = c;
    exp_q.push_back(model(a, b, f, c));
    tag_q.push_back(tag);
  endtask

  // monitor: pops one expected item per cycle, away from the driving edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [W:0] e;
      string      t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if ({carry_out, result} !== e) begin
        errors++;
        $display("FAIL %s: got cout=%0b res=%02h expected cout=%0b res=%02h",
                 t, carry_out, result, e[W], e[W-1:0]);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got %0d cycles expected < %0d", cycles, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-state / idle: all zero inputs give zero outputs (R2)
    drive('0, '0, 2'b00, 1'b0, "R2 idle");
    // R8 full ripple cases
    drive(8'hFF, 8'h00, 2'b00, 1'b1, "R8 ff+00+1");
    drive(8'h01, 8'hFF, 2'b00, 1'b0, "R8 01+ff");
    drive(8'hFF, 8'hFF, 2'b00, 1'b1, "R8 ff+ff+1");
    drive(8'h55, 8'hAA, 2'b00, 1'b1, "R8 55+aa+1");
    drive(8'h55, 8'hAA, 2'b00, 1'b0, "R2 55+aa");
    // R6/R7: logical ops with all-ones operands and both carry-in values
    for (int f = 1; f < 4; f++) begin
      drive(8'hFF, 8'hFF, f[1:0], 1'b1, "R6 R7 cin=1");
      drive(8'hFF, 8'hFF, f[1:0], 1'b0, "R6 R7 cin=0");
    end
    // R10: same B, different A under NOT B
    drive(8'h00, 8'h3C, 2'b11, 1'b0, "R10 a=00");
    drive(8'hFF, 8'h3C, 2'b11, 1'b1, "R10 a=ff");
    // R1 R3 R4 R5 R2: random operands under each select and carry-in
    for (int n = 0; n < 400; n++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = W'($urandom);
      case (n % 4)
        0: drive(ra, rb, 2'b00, n[2], "R1 R2 add");
        1: drive(ra, rb, 2'b01, n[2], "R1 R3 and");
        2: drive(ra, rb, 2'b10, n[2], "R1 R4 or");
        default: drive(ra, rb, 2'b11, n[2], "R1 R5 notb");
      endcase
    end
    @(posedge clk);
    wait (exp_q.size() == 0);
    @(posedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule